// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Unit

This block keeps the six status flags of an asynchronous serial port and turns them into four interrupt request lines, two DMA trigger lines and a prioritised source code. The transmit and receive datapaths send one-cycle set pulses when the transmit buffer empties, when a frame has fully left the line, when a received byte is ready, and when an overrun, parity or framing error is seen. Three enable inputs from a control register gate the requests. The receive enable is shared by the data-ready request and the error request.

Software clears a flag by reading the status word and then writing 0 to that bit. A DMA engine that has completed a transfer pulses a done input, which clears the transmit-empty or receive-full flag without any CPU action. Each request is a registered level that goes to the interrupt controller on its own wire. A 2-bit code names the highest-priority active request.

Top module: `sciu_irq_unit`

## Requirements
- R1: Reset leaves the status word at 6'b000011: transmit-end (bit 0) and transmit-empty (bit 1) are 1, and the bits for receive-full (bit 2), overrun (bit 3), framing (bit 4) and parity (bit 5) are 0. After reset every request output is 0 and src_valid_o is 0.
- R2: A set pulse on a datapath input makes its status bit read 1 from the edge where the pulse is sampled.
- R3: A status write clears bit i only if wdata bit i is 0 and bit i read as 1 at the latest status read before the write. Writing 1 leaves a bit unchanged. Writing 0 with no prior read of 1 leaves it unchanged. Any write disarms every bit.
- R4: If a set pulse and a clear (from the CPU or from DMA) reach the same bit in the same cycle, the bit ends at 1.
- R5: req_txempty_o equals (transmit-empty flag AND en_txe_i) and req_txend_o equals (transmit-end flag AND en_tend_i), each taken one cycle earlier.
- R6: req_rxfull_o equals (receive-full AND en_rx_i) one cycle earlier. req_rxerr_o equals ((overrun OR framing OR parity) AND en_rx_i) one cycle earlier.
- R7: dma_tx_req_o always equals req_txempty_o and dma_rx_req_o always equals req_rxfull_o. The transmit-end and receive-error requests drive no DMA line.
- R8: A dma_tx_done_i pulse clears transmit-empty, and a dma_rx_done_i pulse clears receive-full, from the next edge.
- R9: src_code_o gives the highest active request as 0 = receive error, 1 = receive full, 2 = transmit empty, 3 = transmit end, with 0 the highest priority. src_valid_o is 1 when any request is active, and src_code_o is 0 when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txe_set_i | input | 1 | Transmit buffer became empty |
| tend_set_i | input | 1 | Transmission finished |
| rxf_set_i | input | 1 | Received byte ready |
| ovr_set_i | input | 1 | Overrun detected |
| frm_set_i | input | 1 | Framing error detected |
| par_set_i | input | 1 | Parity error detected |
| en_txe_i | input | 1 | Transmit-empty request enable |
| en_tend_i | input | 1 | Transmit-end request enable |
| en_rx_i | input | 1 | Receive-full and receive-error enable |
| dma_tx_done_i | input | 1 | DMA finished a transmit transfer |
| dma_rx_done_i | input | 1 | DMA finished a receive transfer |
| stat_rd_i | input | 1 | Status read strobe (arms clears) |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 6 | Status write data |
| stat_o | output | 6 | Status word |
| req_rxerr_o | output | 1 | Receive-error request |
| req_rxfull_o | output | 1 | Receive-full request |
| req_txempty_o | output | 1 | Transmit-empty request |
| req_txend_o | output | 1 | Transmit-end request |
| dma_tx_req_o | output | 1 | DMA trigger, transmit side |
| dma_rx_req_o | output | 1 | DMA trigger, receive side |
| src_code_o | output | 2 | Highest active source |
| src_valid_o | output | 1 | Any request active |

## Verification
The bench writes 0 to a flag that was never read as 1. A design that skips the arming step would drop that flag. The bench also pulses a set and a clear into the same bit in the same cycle, from the CPU side and from the DMA side. A design where the clear wins would lose an event and show the bit as 0. Errors are raised while receive-full is pending, so a wrong priority order or an error routed to a DMA line shows up in src_code_o or dma_rx_req_o. The enables are toggled with flags held, which shows whether a request drops a cycle late, or not at all.

// File: rtl/sciu_pkg.sv
package sciu_pkg;
  localparam int FLAG_W   = 6;
  localparam int BIT_TEND = 0;
  localparam int BIT_TXE  = 1;
  localparam int BIT_RXF  = 2;
  localparam int BIT_OVR  = 3;
  localparam int BIT_FRM  = 4;
  localparam int BIT_PAR  = 5;
  localparam logic [FLAG_W-1:0] FLAG_RST = 6'b000011;

  localparam int NUM_SRC  = 4;
  localparam int SRC_W    = $clog2(NUM_SRC);
  // request index equals priority rank, 0 highest
  localparam int SRC_ERR  = 0;
  localparam int SRC_RXF  = 1;
  localparam int SRC_TXE  = 2;
  localparam int SRC_TEND = 3;
endpackage

// File: rtl/sciu_flag_bank.sv
module sciu_flag_bank #(
  parameter int            W       = 6,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] arm_q;
  logic [W-1:0] cpu_clr;

  assign cpu_clr = {W{wr_i}} & arm_q & ~wdata_i;

  // arm bits remember which flags were seen as 1 by the last read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   arm_q <= '0;
    else if (rd_i) arm_q <= flag_q;
    else if (wr_i) arm_q <= '0;
  end

  for (genvar g = 0; g < W; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flag_q[g] <= RST_VAL[g];
      else if (set_i[g])                  flag_q[g] <= 1'b1;
      else if (cpu_clr[g] || hw_clr_i[g]) flag_q[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]); // R4
    AST_NO_BLIND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !arm_q[g] && !hw_clr_i[g]) |=> flag_q[g]); // R3
    AST_HW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_clr_i[g] && !set_i[g]) |=> !flag_q[g]); // R8
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/sciu_req_gen.sv
module sciu_req_gen
  import sciu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic               en_txe_i,
  input  logic               en_tend_i,
  input  logic               en_rx_i,
  output logic [NUM_SRC-1:0] act_o,
  output logic [NUM_SRC-1:0] req_o
);
  logic [NUM_SRC-1:0] req_q;
  logic               any_err;

  assign any_err = flags_i[BIT_OVR] | flags_i[BIT_FRM] | flags_i[BIT_PAR];

  always_comb begin
    act_o           = '0;
    act_o[SRC_ERR]  = any_err           & en_rx_i;
    act_o[SRC_RXF]  = flags_i[BIT_RXF]  & en_rx_i;
    act_o[SRC_TXE]  = flags_i[BIT_TXE]  & en_txe_i;
    act_o[SRC_TEND] = flags_i[BIT_TEND] & en_tend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= act_o;
  end

  assign req_o = req_q;

  AST_RX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_rx_i |=> (!req_q[SRC_ERR] && !req_q[SRC_RXF])); // R6
  AST_TXE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_txe_i |=> !req_q[SRC_TXE]); // R5
  AST_TEND_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_tend_i |=> !req_q[SRC_TEND]); // R5
endmodule

// File: rtl/sciu_prio_enc.sv
module sciu_prio_enc #(
  parameter int N  = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  act_i,
  output logic [CW-1:0] code_o,
  output logic          valid_o
);
  logic [N-1:0]  higher;
  logic [N-1:0]  grant;
  logic [CW-1:0] code_d;
  logic [CW-1:0] code_q;
  logic          valid_q;

  assign higher[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign higher[i] = higher[i-1] | act_i[i-1];
  end
  assign grant = act_i & ~higher;

  always_comb begin
    code_d = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) code_d = code_d | CW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      valid_q <= |act_i;
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sciu_irq_unit.sv
module sciu_irq_unit
  import sciu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txe_set_i,
  input  logic              tend_set_i,
  input  logic              rxf_set_i,
  input  logic              ovr_set_i,
  input  logic              frm_set_i,
  input  logic              par_set_i,
  input  logic              en_txe_i,
  input  logic              en_tend_i,
  input  logic              en_rx_i,
  input  logic              dma_tx_done_i,
  input  logic              dma_rx_done_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [FLAG_W-1:0] stat_wdata_i,
  output logic [FLAG_W-1:0] stat_o,
  output logic              req_rxerr_o,
  output logic              req_rxfull_o,
  output logic              req_txempty_o,
  output logic              req_txend_o,
  output logic              dma_tx_req_o,
  output logic              dma_rx_req_o,
  output logic [SRC_W-1:0]  src_code_o,
  output logic              src_valid_o
);
  logic [FLAG_W-1:0]  set_vec;
  logic [FLAG_W-1:0]  hw_clr;
  logic [FLAG_W-1:0]  flags;
  logic [NUM_SRC-1:0] act;
  logic [NUM_SRC-1:0] req;

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_TEND] = tend_set_i;
    set_vec[BIT_TXE]  = txe_set_i;
    set_vec[BIT_RXF]  = rxf_set_i;
    set_vec[BIT_OVR]  = ovr_set_i;
    set_vec[BIT_FRM]  = frm_set_i;
    set_vec[BIT_PAR]  = par_set_i;
    hw_clr            = '0;
    hw_clr[BIT_TXE]   = dma_tx_done_i;
    hw_clr[BIT_RXF]   = dma_rx_done_i;
  end

  sciu_flag_bank #(.W(FLAG_W), .RST_VAL(FLAG_RST)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .hw_clr_i (hw_clr),
    .rd_i     (stat_rd_i),
    .wr_i     (stat_wr_i),
    .wdata_i  (stat_wdata_i),
    .flags_o  (flags)
  );

  sciu_req_gen u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flags_i   (flags),
    .en_txe_i  (en_txe_i),
    .en_tend_i (en_tend_i),
    .en_rx_i   (en_rx_i),
    .act_o     (act),
    .req_o     (req)
  );

  sciu_prio_enc #(.N(NUM_SRC)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .code_o  (src_code_o),
    .valid_o (src_valid_o)
  );

  assign stat_o        = flags;
  assign req_rxerr_o   = req[SRC_ERR];
  assign req_rxfull_o  = req[SRC_RXF];
  assign req_txempty_o = req[SRC_TXE];
  assign req_txend_o   = req[SRC_TEND];
  assign dma_tx_req_o  = req[SRC_TXE];
  assign dma_rx_req_o  = req[SRC_RXF];

  AST_CODE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o |-> req[src_code_o]); // R9
  AST_VALID_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o == (|req)); // R9
  AST_ERR_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req[SRC_ERR] |-> (src_code_o == SRC_W'(SRC_ERR))); // R9
  AST_ERR_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req[SRC_ERR] && !req[SRC_RXF]) |-> !dma_rx_req_o); // R7
  AST_TEND_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req[SRC_TEND] && !req[SRC_TXE]) |-> !dma_tx_req_o); // R7
endmodule

// File: tb/sciu_irq_unit_tb_top.sv
`timescale 1ns/1ps
module sciu_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic txe_set = 0, tend_set = 0, rxf_set = 0, ovr_set = 0, frm_set = 0, par_set = 0;
  logic en_txe = 0, en_tend = 0, en_rx = 0, dtx = 0, drx = 0, rd = 0, wr = 0;
  logic [5:0] wdata = '0;
  logic [5:0] stat;
  logic r_err, r_rxf, r_txe, r_tend, d_tx, d_rx, vld;
  logic [1:0] code;

  sciu_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .txe_set_i(txe_set), .tend_set_i(tend_set), .rxf_set_i(rxf_set),
    .ovr_set_i(ovr_set), .frm_set_i(frm_set), .par_set_i(par_set),
    .en_txe_i(en_txe), .en_tend_i(en_tend), .en_rx_i(en_rx),
    .dma_tx_done_i(dtx), .dma_rx_done_i(drx),
    .stat_rd_i(rd), .stat_wr_i(wr), .stat_wdata_i(wdata),
    .stat_o(stat), .req_rxerr_o(r_err), .req_rxfull_o(r_rxf),
    .req_txempty_o(r_txe), .req_txend_o(r_tend),
    .dma_tx_req_o(d_tx), .dma_rx_req_o(d_rx),
    .src_code_o(code), .src_valid_o(vld)
  );

  typedef struct {
    string      tag;
    logic [5:0] stat;
    logic [3:0] req;   // {tend, txe, rxf, err}
    logic [1:0] dma;   // {rx, tx}
    logic [1:0] code;
    logic       vld;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [5:0] m_flag = 6'b000011, m_arm = '0;
  logic [3:0] m_req = '0;
  logic [1:0] m_code = '0;
  logic       m_vld = 0;

  // driver: one clock, model advanced from the requirements, result queued
  task automatic cyc(string tag);
    logic [5:0] s, c, nf;
    logic [3:0] a;
    logic [1:0] nc;
    s = {par_set, frm_set, ovr_set, rxf_set, txe_set, tend_set};
    c = ({6{wr}} & m_arm & ~wdata) | {3'b000, drx, dtx, 1'b0};
    nf = (m_flag & ~c) | s;
    a[0] = (|m_flag[5:3]) & en_rx;
    a[1] = m_flag[2] & en_rx;
    a[2] = m_flag[1] & en_txe;
    a[3] = m_flag[0] & en_tend;
    nc = a[0] ? 2'd0 : a[1] ? 2'd1 : a[2] ? 2'd2 : a[3] ? 2'd3 : 2'd0;
    @(posedge clk);
    #1;
    if (rd) m_arm = m_flag; else if (wr) m_arm = '0;
    m_flag = nf; m_req = a; m_code = nc; m_vld = |a;
    q.push_back('{tag, m_flag, m_req, {m_req[1], m_req[2]}, m_code, m_vld});
    {txe_set, tend_set, rxf_set, ovr_set, frm_set, par_set} = '0;
    {dtx, drx, rd, wr} = '0;
    wdata = '0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [3:0] r;
        e = q.pop_front();
        r = {r_tend, r_txe, r_rxf, r_err};
        total++;
        if (stat !== e.stat || r !== e.req || {d_rx, d_tx} !== e.dma ||
            code !== e.code || vld !== e.vld) begin
          bad++;
          $display("FAIL %s: act stat=%b req=%b dma=%b code=%0d vld=%b exp stat=%b req=%b dma=%b code=%0d vld=%b",
                   e.tag, stat, r, {d_rx, d_tx}, code, vld,
                   e.stat, e.req, e.dma, e.code, e.vld);
        end
      end
    end
  end

  task automatic direct(string tag, logic ok, logic [7:0] act_v, logic [7:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    direct("R1 stat", stat == 6'b000011, {2'b0, stat}, 8'h03);
    direct("R1 reqs", {r_err, r_rxf, r_txe, r_tend, d_tx, d_rx, vld} == '0,
           {1'b0, r_err, r_rxf, r_txe, r_tend, d_tx, d_rx, vld}, 8'h00);
    cyc("R1");
    // R5 transmit-empty request and DMA mirror (R7)
    en_txe = 1; cyc("R5 txe enable");
    cyc("R7 tx dma");
    en_tend = 1; cyc("R9 txe over tend");
    cyc("R5 tend req");
    // R8 DMA clears transmit-empty
    dtx = 1; cyc("R8 dma tx clear");
    cyc("R5 txe drops");
    direct("R8 txe bit", stat[1] == 1'b0, {2'b0, stat}, 8'h01);
    cyc("R9 tend alone");
    // R2 receive-full, gated by R6
    rxf_set = 1; cyc("R2 rxf set");
    cyc("R6 rx gated");
    en_rx = 1; cyc("R6 rx enable");
    cyc("R7 rx dma");
    // R6 error request and priority R9
    par_set = 1; cyc("R2 par set");
    cyc("R9 err highest");
    // R3 clear without read: no effect
    wr = 1; wdata = 6'b000000; cyc("R3 blind write");
    cyc("R3 blind hold");
    direct("R3 par held", stat[5] == 1'b1, {2'b0, stat}, 8'h25);
    // read then write 1s: no change
    rd = 1; cyc("R3 read");
    wr = 1; wdata = 6'b111111; cyc("R3 write ones");
    // read then write 0 to parity only
    rd = 1; cyc("R3 read2");
    wr = 1; wdata = 6'b011111; cyc("R3 clear par");
    cyc("R6 err drops");
    direct("R3 par clear", stat[5] == 1'b0, {2'b0, stat}, 8'h05);
    // R4 set and CPU clear same cycle
    frm_set = 1; cyc("R2 frm set");
    rd = 1; cyc("R4 read");
    wr = 1; wdata = 6'b101111; frm_set = 1; cyc("R4 set vs cpu clr");
    direct("R4 frm kept", stat[4] == 1'b1, {2'b0, stat}, 8'h15);
    // R4 set and DMA clear same cycle
    drx = 1; rxf_set = 1; cyc("R4 set vs dma clr");
    drx = 1; cyc("R8 dma rx clear");
    cyc("R7 err no dma");
    ovr_set = 1; tend_set = 1; txe_set = 1; cyc("R2 ovr tend txe");
    rd = 1; cyc("R3 read3");
    wr = 1; wdata = 6'b000000; cyc("R3 clear all");
    cyc("R9 none");
    en_txe = 0; en_tend = 0; en_rx = 0; txe_set = 1; cyc("R5 disabled");
    cyc("R5 disabled hold");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule